// File: doc/BRIEF.md
# Debug Operating-Mode Controller

This block keeps track of which debug mode a processor core is in and drives the control outputs that depend on that mode. There are three modes: running with debug disabled, running with debug enabled, and halted. While halted, the core runs no application code and only serves serial debug commands. The block takes strobes that have already been decoded: enable set and clear, background request, resume (GO), halt-instruction execution and breakpoint trigger. Each strobe is one clock cycle long. The block decides the next mode from these strobes.

Reset is synchronous and active high. While reset is asserted, a power-on flag and the sampled level of the debug pin choose the starting mode. A power-on reset with the pin low boots straight into halt, and the debug enable and debug clock-select are both set. The clock-select output picks the CPU clock divided by two (1) or an alternate clock (0) for the debug serial link. The stop-keepalive output tells the clock system to keep the core and debug clocks running through stop and wait modes. It also tells it that a debug command may wake the device. If a halt instruction runs while debug is disabled, it is treated as illegal. The block then sends a one-cycle reset request or exception request, depending on a disposition bit.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While `rst` is high with `por_i`=1 and `dbg_pin_i`=0, the outputs after the clock edge are: `mode_o`=2 (halt), `halted_o`=1, `clksel_o`=1, `keep_clk_o`=1, and no illegal-halt pulse.
- R2: Any other reset gives `mode_o`=0 (debug disabled) with `halted_o`, `clksel_o` and `keep_clk_o` all 0. This covers `por_i`=1 with `dbg_pin_i`=1, and any reset with `por_i`=0.
- R3: Mode encoding is 0 = disabled, 1 = enabled, 2 = halt, and 3 never occurs. From disabled, `en_set_i` moves to enabled. From enabled, `en_clr_i` moves to disabled unless a halt cause is present in the same cycle. Each change shows on the outputs one clock after the strobe.
- R4: From enabled, any of `halt_ins_i`, `bgnd_i` or `brk_i` moves to halt. A halt cause wins over `en_clr_i` in the same cycle.
- R5: From halt, `go_i` moves to enabled. `go_i` has no effect in disabled or enabled. `bgnd_i` and `brk_i` have no effect in disabled.
- R6: From halt, `en_clr_i` without `go_i` moves to disabled. When both arrive together, `go_i` wins and the block moves to enabled.
- R7: `halt_ins_i` while in disabled mode leaves the mode unchanged. One clock later it raises `ill_rst_o` for exactly one cycle when `ill_disp_i`=0, or `ill_exc_o` for exactly one cycle when `ill_disp_i`=1. In the enabled and halt modes no such pulse is raised.
- R8: `halted_o` is 1 exactly when `mode_o`=2. `keep_clk_o` is 1 exactly when `mode_o` is not 0.
- R9: `clksel_o` changes only under reset. The mode commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Current reset is a power-on reset |
| dbg_pin_i | input | 1 | Debug pin level sampled during reset |
| en_set_i | input | 1 | Set-debug-enable command strobe |
| en_clr_i | input | 1 | Clear-debug-enable command strobe |
| bgnd_i | input | 1 | Background (halt request) command strobe |
| go_i | input | 1 | Resume command strobe |
| halt_ins_i | input | 1 | Core executed a halt instruction |
| brk_i | input | 1 | Breakpoint trigger |
| ill_disp_i | input | 1 | Illegal halt disposition: 0 reset, 1 exception |
| mode_o | output | 2 | Current mode (0 disabled, 1 enabled, 2 halt) |
| halted_o | output | 1 | Core is halted |
| clksel_o | output | 1 | Debug clock select (1 = CPU clock / 2) |
| keep_clk_o | output | 1 | Keep clocks running in stop modes |
| ill_rst_o | output | 1 | One-cycle illegal-halt reset request |
| ill_exc_o | output | 1 | One-cycle illegal-halt exception request |

## Verification
Each halt cause is applied once in each mode. Firing halt, background, breakpoint and GO while disabled shows that only the halt instruction has an effect there, and that its effect is a pulse rather than a mode change. Firing the same strobes while enabled or halted shows that they are gated by the enable. Clear-enable is paired with a halt cause and with GO to settle the two same-cycle priorities. The three reset flavours, each followed by mode commands, separate the boot-into-halt path from the plain start and show that the clock select holds through later traffic.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 2'd0,
    MODE_ARMED = 2'd1,
    MODE_HALT  = 2'd2
  } dbg_mode_e;
endpackage

// File: rtl/dbgm_mode_fsm.sv
module dbgm_mode_fsm
  import dbgm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      boot_halt,
  input  logic      en_set,
  input  logic      en_clr,
  input  logic      bgnd,
  input  logic      go,
  input  logic      halt_ins,
  input  logic      brk,
  output dbg_mode_e mode_q,
  output dbg_mode_e mode_d,
  output logic      clksel_q
);
  logic halt_cause;
  assign halt_cause = halt_ins | bgnd | brk;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_OFF:   if (en_set) mode_d = MODE_ARMED;
      MODE_ARMED: begin
        if (halt_cause)  mode_d = MODE_HALT;
        else if (en_clr) mode_d = MODE_OFF;
      end
      MODE_HALT: begin
        if (go)          mode_d = MODE_ARMED;
        else if (en_clr) mode_d = MODE_OFF;
      end
      default:    mode_d = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= boot_halt ? MODE_HALT : MODE_OFF;
      clksel_q <= boot_halt;
    end else begin
      mode_q   <= mode_d;
    end
  end

  assert_legal_mode_R3: assert property (@(posedge clk) disable iff (rst)
    mode_q != dbg_mode_e'(2'd3));
  assert_halt_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ARMED && halt_cause) |=> mode_q == MODE_HALT);
  assert_go_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_HALT && go) |=> mode_q == MODE_ARMED);
  assert_off_ignores_bg_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_OFF && !en_set) |=> mode_q == MODE_OFF);
endmodule

// File: rtl/dbgm_illegal.sv
module dbgm_illegal (
  input  logic clk,
  input  logic rst,
  input  logic dbg_enabled,
  input  logic halt_ins,
  input  logic disp,
  output logic ill_rst_q,
  output logic ill_exc_q
);
  logic bad_halt;
  assign bad_halt = halt_ins & ~dbg_enabled;

  always_ff @(posedge clk) begin
    if (rst) begin
      ill_rst_q <= 1'b0;
      ill_exc_q <= 1'b0;
    end else begin
      ill_rst_q <= bad_halt & ~disp;
      ill_exc_q <= bad_halt & disp;
    end
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    (ill_rst_q | ill_exc_q) |-> $past(!dbg_enabled && halt_ins));
  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ill_rst_q, ill_exc_q}));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbgm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              por_i,
  input  logic              dbg_pin_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              bgnd_i,
  input  logic              go_i,
  input  logic              halt_ins_i,
  input  logic              brk_i,
  input  logic              ill_disp_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              halted_o,
  output logic              clksel_o,
  output logic              keep_clk_o,
  output logic              ill_rst_o,
  output logic              ill_exc_o
);
  logic      boot_halt;
  dbg_mode_e mode_q, mode_d;
  logic      halted_q, keep_q;

  assign boot_halt = por_i & ~dbg_pin_i;

  dbgm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .boot_halt(boot_halt),
    .en_set(en_set_i), .en_clr(en_clr_i), .bgnd(bgnd_i), .go(go_i),
    .halt_ins(halt_ins_i), .brk(brk_i),
    .mode_q(mode_q), .mode_d(mode_d), .clksel_q(clksel_o)
  );

  dbgm_illegal u_ill (
    .clk(clk), .rst(rst), .dbg_enabled(mode_q != MODE_OFF),
    .halt_ins(halt_ins_i), .disp(ill_disp_i),
    .ill_rst_q(ill_rst_o), .ill_exc_q(ill_exc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= boot_halt;
      keep_q   <= boot_halt;
    end else begin
      halted_q <= (mode_d == MODE_HALT);
      keep_q   <= (mode_d != MODE_OFF);
    end
  end

  assign mode_o     = mode_q;
  assign halted_o   = halted_q;
  assign keep_clk_o = keep_q;

  assert_halted_flag_R8: assert property (@(posedge clk) disable iff (rst)
    halted_o == (mode_o == MODE_HALT));
  assert_keep_flag_R8: assert property (@(posedge clk) disable iff (rst)
    keep_clk_o == (mode_o != MODE_OFF));
  assert_clksel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(clksel_o));
endmodule

// File: tb/sim_dbg_mode_ctrl.sv
module sim_dbg_mode_ctrl;
  logic clk = 1'b0, rst = 1'b1, por = 1'b1, pin = 1'b1;
  logic en_set = 0, en_clr = 0, bgnd = 0, go = 0, hlt = 0, brk = 0, disp = 0;
  logic [1:0] mode;
  logic halted, clksel, keep, irst, iexc;
  int compared = 0, mismatched = 0;
  bit done = 0;

  typedef struct { logic [6:0] exp; string tag; } item_t;
  item_t sb[$];

  localparam logic [6:0] S_SET = 7'h40, S_CLR = 7'h20, S_BG = 7'h10, S_GO = 7'h08,
                         S_HLT = 7'h04, S_BRK = 7'h02, S_DSP = 7'h01;

  always #5 clk = ~clk;

  dbg_mode_ctrl u0 (
    .clk(clk), .rst(rst), .por_i(por), .dbg_pin_i(pin),
    .en_set_i(en_set), .en_clr_i(en_clr), .bgnd_i(bgnd), .go_i(go),
    .halt_ins_i(hlt), .brk_i(brk), .ill_disp_i(disp),
    .mode_o(mode), .halted_o(halted), .clksel_o(clksel), .keep_clk_o(keep),
    .ill_rst_o(irst), .ill_exc_o(iexc)
  );

  function automatic logic [6:0] ex(input logic [1:0] m, input logic h, c, k, r, e);
    return {m, h, c, k, r, e};
  endfunction

  task automatic step(input logic [6:0] s, input logic [6:0] e, input string tag);
    @(negedge clk);
    rst = 0;
    {en_set, en_clr, bgnd, go, hlt, brk, disp} = s;
    sb.push_back('{e, tag});
  endtask

  task automatic do_reset(input logic p, input logic l, input logic [6:0] e, input string tag);
    @(negedge clk);
    rst = 1; por = p; pin = l;
    {en_set, en_clr, bgnd, go, hlt, brk, disp} = '0;
    sb.push_back('{e, tag});
  endtask

  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      item_t it;
      logic [6:0] act;
      it = sb.pop_front();
      act = {mode, halted, clksel, keep, irst, iexc};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: actual {mode,halt,clk,keep,irst,iexc}=%b expected %b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    // plain power-on reset
    do_reset(1, 1, ex(0,0,0,0,0,0), "R2 por pin high");
    step(0, ex(0,0,0,0,0,0), "R2 idle after reset");
    step(S_BG, ex(0,0,0,0,0,0), "R5 bgnd ignored when disabled");
    step(S_GO, ex(0,0,0,0,0,0), "R5 go ignored when disabled");
    step(S_BRK, ex(0,0,0,0,0,0), "R5 brk ignored when disabled");
    step(S_HLT, ex(0,0,0,0,1,0), "R7 illegal halt reset pulse");
    step(0, ex(0,0,0,0,0,0), "R7 reset pulse one cycle");
    step(S_HLT | S_DSP, ex(0,0,0,0,0,1), "R7 illegal halt exception pulse");
    step(0, ex(0,0,0,0,0,0), "R7 exception pulse one cycle");
    step(S_SET, ex(1,0,0,1,0,0), "R3 set enable");
    step(S_GO, ex(1,0,0,1,0,0), "R5 go ignored when enabled");
    step(S_HLT, ex(2,1,0,1,0,0), "R4 halt instr enters halt no pulse R7");
    step(S_GO, ex(1,0,0,1,0,0), "R5 go resumes");
    step(S_BG, ex(2,1,0,1,0,0), "R4 background enters halt");
    step(S_GO, ex(1,0,0,1,0,0), "R5 go resumes");
    step(S_BRK, ex(2,1,0,1,0,0), "R4 breakpoint enters halt");
    step(S_HLT, ex(2,1,0,1,0,0), "R7 halt instr in halt no pulse");
    step(S_GO | S_CLR, ex(1,0,0,1,0,0), "R6 go beats clear");
    step(S_HLT | S_CLR, ex(2,1,0,1,0,0), "R4 halt beats clear");
    step(S_CLR, ex(0,0,0,0,0,0), "R6 clear from halt");
    step(S_SET, ex(1,0,0,1,0,0), "R3 set enable again");
    step(S_CLR, ex(0,0,0,0,0,0), "R3 clear enable R8");
    // non-power-on reset with pin low
    do_reset(0, 0, ex(0,0,0,0,0,0), "R2 non-por reset");
    // boot into halt
    do_reset(1, 0, ex(2,1,1,1,0,0), "R1 boot into halt");
    step(0, ex(2,1,1,1,0,0), "R1 halt held");
    step(S_GO, ex(1,0,1,1,0,0), "R9 clksel kept after go");
    step(S_CLR, ex(0,0,1,0,0,0), "R9 clksel kept after clear");
    step(S_HLT, ex(0,0,1,0,1,0), "R7 illegal after boot");
    do_reset(1, 1, ex(0,0,0,0,0,0), "R2 reset clears clksel");
    step(0, ex(0,0,0,0,0,0), "R2 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule